// File: doc/BRIEF.md
# Pin Interrupt Event Detector

This block watches a vector of already-synchronized general-purpose input pins and turns selected activity on them into interrupt status. Each pin is configured on its own. It can latch a rising edge, a falling edge or either edge, or it can track a high or low level. Every pin has a pending-status bit that is visible both before and after a per-pin enable mask. The enabled bits are combined into a single interrupt request.

Software configures the block and services it through a small register port. The port has one address bus and one write strobe, and read data is combinational on the address. Three per-pin configuration words select the sensing mode: a sense-kind word, an any-edge word and a polarity word. A fourth word holds the interrupt enable mask. Pending edge events are removed by writing ones to a clear word. A level-sensed pin cannot be cleared while its level is still active.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low. Pins held high while reset is asserted and after it is released produce no pending status.
- R2: The sense-kind word (offset 0x404, 1 = level, 0 = edge), the any-edge word (0x408), the polarity word (0x40C, 1 = rising/high, 0 = falling/low) and the enable mask (0x410) read back the value last written. A write to one of them takes effect at the clock edge of the write.
- R3: For an edge-sensed pin with polarity 1 and any-edge 0, a low-to-high change between two consecutive clock samples sets its raw status bit. The bit is readable after that second clock edge.
- R4: For an edge-sensed pin with polarity 0 and any-edge 0, a high-to-low change sets its raw bit, and a rising change does not.
- R5: For an edge-sensed pin with any-edge 1, both a rising and a falling change set its raw bit, whatever the polarity bit holds.
- R6: For edge-sensed pins the raw bit stays set until a write to the clear word (0x41C) has a 1 in that bit position. A 0 in that position leaves the bit unchanged.
- R7: For a level-sensed pin the raw bit equals the active level (high when polarity is 1, low when polarity is 0) sampled at the previous clock edge. A clear write has no lasting effect, and the any-edge bit is ignored.
- R8: The raw status word (0x414) and the masked status word (0x418, equal to raw AND mask) are read-only. Writes to them change no register.
- R9: `irq` is high exactly when some masked status bit is 1.
- R10: When an edge is detected on a pin in the same cycle that a clear for that pin is written, the raw bit ends up set.
- R11: The clear word always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_s | input | NPINS | Synchronized pin levels |
| bus_addr | input | 12 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of all masked status bits |

## Verification
A pin change applied before clock edge k is compared with the sample from edge k-1, and the result shows in raw status and `irq` right after edge k. A configuration or clear write made in the cycle that ends at edge k is visible in read-back after edge k. It governs detection only from edge k+1 onward, but a clear and an edge at the same edge k are resolved together. Each bench step drives pins and writes half a cycle before a rising edge, then moves the address onto the register of interest shortly after that edge and samples the combinational read data before the following falling edge. Every result is therefore checked in the one cycle it is due. Pin changes are never applied in the same step as a configuration write, so the edge that uses the new setting is never ambiguous.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

   localparam logic [11:0] OFS_SENSE = 12'h404;
   localparam logic [11:0] OFS_ANYEDGE = 12'h408;
   localparam logic [11:0] OFS_POLAR = 12'h40C;
   localparam logic [11:0] OFS_ENABLE = 12'h410;
   localparam logic [11:0] OFS_RAW = 12'h414;
   localparam logic [11:0] OFS_MSTAT = 12'h418;
   localparam logic [11:0] OFS_CLEAR = 12'h41C;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_SENSE,
      RS_ANYEDGE,
      RS_POLAR,
      RS_ENABLE,
      RS_RAW,
      RS_MSTAT,
      RS_CLEAR
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [11:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_SENSE:   s = RS_SENSE;
         OFS_ANYEDGE: s = RS_ANYEDGE;
         OFS_POLAR:   s = RS_POLAR;
         OFS_ENABLE:  s = RS_ENABLE;
         OFS_RAW:     s = RS_RAW;
         OFS_MSTAT:   s = RS_MSTAT;
         OFS_CLEAR:   s = RS_CLEAR;
         default:     s = RS_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] lvl_mode,
   output logic [NPINS-1:0] any_edge,
   output logic [NPINS-1:0] pol_hi,
   output logic [NPINS-1:0] enable,
   output logic [NPINS-1:0] clr_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_mode <= '0;
         any_edge <= '0;
         pol_hi   <= '0;
         enable   <= '0;
      end else if (wr_en) begin
         case (sel)
            RS_SENSE:   lvl_mode <= wdata;
            RS_ANYEDGE: any_edge <= wdata;
            RS_POLAR:   pol_hi   <= wdata;
            RS_ENABLE:  enable   <= wdata;
            default:    ;
         endcase
      end
   end

   always_comb clr_pulse = (wr_en && sel == RS_CLEAR) ? wdata : '0;

   // R8: writes to other offsets (including the status words) leave the mask alone
   p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel != RS_ENABLE) |=> $stable(enable));

   // R2: a write to the sense word lands at the next edge
   p_sense_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == RS_SENSE) |=> (lvl_mode == $past(wdata)));

endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic lvl_mode,
   input  logic any_edge,
   input  logic pol_hi,
   input  logic clr,
   output logic raw
);

   logic prev_q;
   logic raw_q;
   logic rise;
   logic fall;
   logic edge_hit;
   logic lvl_hit;
   logic raw_d;

   always_comb begin
      rise     = pin_s & ~prev_q;
      fall     = ~pin_s & prev_q;
      edge_hit = any_edge ? (rise | fall) : (pol_hi ? rise : fall);
      lvl_hit  = pol_hi ? pin_s : ~pin_s;
      // a fresh edge beats a simultaneous clear
      raw_d    = lvl_mode ? lvl_hit : (edge_hit | (raw_q & ~clr));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         prev_q <= pin_s;
         raw_q  <= raw_d;
      end
   end

   assign raw = raw_q;

   p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && !any_edge && pol_hi && pin_s && !prev_q) |=> raw_q);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && raw_q && !clr) |=> raw_q);

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && clr && !edge_hit) |=> !raw_q);

   p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && clr && edge_hit) |=> raw_q);

   p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode |=> (raw_q == $past(pol_hi ~^ pin_s)));

endmodule

// File: rtl/pin_irq_rdmux.sv
module pin_irq_rdmux
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  reg_sel_e         sel,
   input  logic [NPINS-1:0] lvl_mode,
   input  logic [NPINS-1:0] any_edge,
   input  logic [NPINS-1:0] pol_hi,
   input  logic [NPINS-1:0] enable,
   input  logic [NPINS-1:0] raw,
   output logic [NPINS-1:0] mstat,
   output logic [NPINS-1:0] rdata
);

   always_comb begin
      mstat = raw & enable;
      case (sel)
         RS_SENSE:   rdata = lvl_mode;
         RS_ANYEDGE: rdata = any_edge;
         RS_POLAR:   rdata = pol_hi;
         RS_ENABLE:  rdata = enable;
         RS_RAW:     rdata = raw;
         RS_MSTAT:   rdata = mstat;
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_s,
   input  logic [11:0]      bus_addr,
   input  logic             bus_wr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   output logic             irq
);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("pin_irq_detect: NPINS must lie in 1..32");
   end

   reg_sel_e         sel;
   logic [NPINS-1:0] lvl_mode;
   logic [NPINS-1:0] any_edge;
   logic [NPINS-1:0] pol_hi;
   logic [NPINS-1:0] enable;
   logic [NPINS-1:0] clr_pulse;
   logic [NPINS-1:0] raw;
   logic [NPINS-1:0] mstat;

   always_comb sel = decode_ofs(bus_addr);

   pin_irq_cfg #(.NPINS(NPINS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .sel       (sel),
      .wdata     (bus_wdata),
      .lvl_mode  (lvl_mode),
      .any_edge  (any_edge),
      .pol_hi    (pol_hi),
      .enable    (enable),
      .clr_pulse (clr_pulse)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_irq_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin_s    (pin_s[i]),
         .lvl_mode (lvl_mode[i]),
         .any_edge (any_edge[i]),
         .pol_hi   (pol_hi[i]),
         .clr      (clr_pulse[i]),
         .raw      (raw[i])
      );
   end

   pin_irq_rdmux #(.NPINS(NPINS)) u_rdmux (
      .sel      (sel),
      .lvl_mode (lvl_mode),
      .any_edge (any_edge),
      .pol_hi   (pol_hi),
      .enable   (enable),
      .raw      (raw),
      .mstat    (mstat),
      .rdata    (bus_rdata)
   );

   assign irq = |mstat;

   // R9: request tracks enabled pending bits from the cells and the mask register
   p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == ((raw & enable) != '0));

endmodule

// File: tb/pin_irq_detect_bench.sv
`timescale 1ns/100ps
module pin_irq_detect_bench;

   typedef struct packed {
      logic [7:0]  pin;
      logic        wr;
      logic [11:0] wa;
      logic [7:0]  wd;
      logic [11:0] ra;
      logic [7:0]  exp;
      logic [3:0]  rq;
   } vec_t;

   // pins | write? | write offset | write data | read offset | expected | requirement number
   localparam vec_t VEC [18] = '{
      '{8'h00, 1'b1, 12'h40C, 8'h0F, 12'h40C, 8'h0F, 4'd2},  // R2 polarity: pins 0-3 rising
      '{8'h00, 1'b1, 12'h404, 8'h30, 12'h404, 8'h30, 4'd2},  // R2 pins 4,5 level
      '{8'h00, 1'b1, 12'h408, 8'h80, 12'h408, 8'h80, 4'd2},  // R2 pin 7 any edge
      '{8'h00, 1'b1, 12'h410, 8'hFF, 12'h410, 8'hFF, 4'd2},  // R2 mask
      '{8'h00, 1'b0, 12'h000, 8'h00, 12'h414, 8'h30, 4'd7},  // R7 low level active
      '{8'h01, 1'b0, 12'h000, 8'h00, 12'h414, 8'h31, 4'd3},  // R3 rising
      '{8'h00, 1'b0, 12'h000, 8'h00, 12'h414, 8'h31, 4'd6},  // R6 sticky
      '{8'h40, 1'b0, 12'h000, 8'h00, 12'h414, 8'h31, 4'd4},  // R4 rise ignored
      '{8'h00, 1'b0, 12'h000, 8'h00, 12'h414, 8'h71, 4'd4},  // R4 falling
      '{8'h80, 1'b0, 12'h000, 8'h00, 12'h414, 8'hF1, 4'd5},  // R5 rise
      '{8'h80, 1'b1, 12'h41C, 8'h80, 12'h414, 8'h71, 4'd6},  // R6 clear one
      '{8'h00, 1'b0, 12'h000, 8'h00, 12'h414, 8'hF1, 4'd5},  // R5 fall
      '{8'h00, 1'b1, 12'h41C, 8'h41, 12'h414, 8'hB0, 4'd6},  // R6 clear two
      '{8'h00, 1'b1, 12'h41C, 8'h30, 12'h414, 8'hB0, 4'd7},  // R7 clear no effect
      '{8'h10, 1'b0, 12'h000, 8'h00, 12'h414, 8'hA0, 4'd7},  // R7 level goes inactive
      '{8'h10, 1'b1, 12'h410, 8'h20, 12'h418, 8'h20, 4'd8},  // R8 masked view
      '{8'h10, 1'b1, 12'h414, 8'hFF, 12'h414, 8'hA0, 4'd8},  // R8 raw read-only
      '{8'h10, 1'b0, 12'h000, 8'h00, 12'h41C, 8'h00, 4'd11}  // R11 clear reads zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_s = 8'hFF;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;

   pin_irq_detect #(.NPINS(8)) u_pin_irq_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_s     (pin_s),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [7:0] pin, input logic wr, input logic [11:0] wa,
                       input logic [7:0] wd, input logic [11:0] ra,
                       input logic [7:0] exp, input string tag);
      @(negedge clk);
      pin_s     = pin;
      bus_wr    = wr;
      bus_addr  = wa;
      bus_wdata = wd;
      @(posedge clk);
      #1;
      bus_wr   = 1'b0;
      bus_addr = ra;
      #0.5;
      check(bus_rdata, exp, tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      // R1: all registers zero, no false event with pins high
      foreach (VEC[k]) begin end
      for (int a = 0; a < 7; a++) begin
         bus_addr = 12'h404 + 12'(a * 4);
         #0.2;
         check(bus_rdata, 8'h00, $sformatf("R1 reset offset %03h", bus_addr));
      end
      check({7'd0, irq}, 8'h00, "R1 irq after reset");

      // R4 default config is falling edge on all pins; then R6 clear all
      step(8'h00, 1'b0, 12'h000, 8'h00, 12'h414, 8'hFF, "R4 default falling");
      step(8'h00, 1'b1, 12'h41C, 8'hFF, 12'h414, 8'h00, "R6 clear all");

      for (int i = 0; i < 18; i++) begin
         step(VEC[i].pin, VEC[i].wr, VEC[i].wa, VEC[i].wd, VEC[i].ra, VEC[i].exp,
              $sformatf("R%0d vector %0d", VEC[i].rq, i));
      end

      // R9: pin 5 high removes its low-level status, only masked source
      step(8'h30, 1'b0, 12'h000, 8'h00, 12'h418, 8'h00, "R9 masked empty");
      check({7'd0, irq}, 8'h00, "R9 irq low");
      step(8'h10, 1'b0, 12'h000, 8'h00, 12'h418, 8'h20, "R9 masked set");
      check({7'd0, irq}, 8'h01, "R9 irq high");

      // R10: rising on pin 0 together with a clear of pin 0
      step(8'h11, 1'b1, 12'h41C, 8'h01, 12'h414, 8'hA1, "R10 edge beats clear");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule